// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against stalled software. A free-running counter advances on every clock. If software does not restart it before it reaches the selected limit, the block emits a one-cycle reset request towards the system reset logic. The block is live from reset in watchdog mode with the longest limit, so it protects the system before any software has run.

The same counter can serve as a periodic interval timer instead. In that mode, reaching the limit sets an interrupt flag and the count starts over, and no reset request is raised. Software controls the block through one 16-bit control word. A write takes effect only when its high byte carries the unlock key. Any other high byte is treated as a fault and produces a reset request at once.

Top module: `wdog_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_data_o` is 0x6900, and `rst_req_o` and `irq_o` are 0. The block then counts in watchdog mode with select 00 and hold off.
- R2: With no writes after reset, `rst_req_o` is high for exactly the one cycle that follows the 32768th rising edge after reset is released.
- R3: A write (`wr_en_i` high at a rising edge) takes effect only when `wr_data_i[15:8]` is 0x5A. The low-byte fields are: bit 7 hold, bit 4 mode (1 = interval, 0 = watchdog), bit 3 clear, bits 1:0 select. `rd_data_o` shows 0x69 in bits 15:8 and the stored fields in the same positions. The clear bit and the other low bits always read 0. `rd_data_o` follows a write one cycle after the write edge.
- R4: Select 00, 01, 10 and 11 give limits of 2^15, 2^13, 2^9 and 2^6 clock edges. After a keyed write with clear at edge E, the counter expires at edge E+limit.
- R5: A keyed write with the clear bit set restarts the count from zero. If that write falls on the expiry edge itself, the expiry is cancelled.
- R6: While hold is set, the count is frozen. After a keyed write that clears hold without setting clear, counting resumes from the frozen value.
- R7: A write whose high byte is not 0x5A raises `rst_req_o` in the cycle after its edge. The block then returns to its reset state, so `rd_data_o` reads 0x6900 and a fresh 2^15 count starts.
- R8: `rst_req_o` is a single-cycle pulse. A watchdog expiry returns the control fields to their reset values and the counter to zero.
- R9: In interval mode an expiry sets `irq_o` and never raises `rst_req_o`. The count restarts from zero, so the flag is set again every limit edges.
- R10: `irq_o` stays set until `irq_ack_i` is high at an edge. If an acknowledge falls on the same edge as a new expiry, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word: key in bits 15:8, fields in bits 7:0 |
| irq_ack_i | input | 1 | Clears the interval flag |
| rd_data_o | output | 16 | Registered read-back of the control word |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Interval-mode interrupt flag |

## Verification
Two events can fall on the same edge: a servicing write that carries the clear bit, and the counter reaching its limit. The bench provokes this by issuing the servicing write exactly 64 edges after an earlier clear with select 11. It judges the result by the absence of a reset pulse at that edge and by a pulse 64 edges after the late write. A second collision pairs the interrupt acknowledge with a new interval expiry; it is judged by the flag still being set afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int HOLD_BIT = 7;
  localparam int MODE_BIT = 4;
  localparam int CLR_BIT  = 3;
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 2;

  typedef struct packed {
    logic             hold;
    logic             interval;
    logic [SEL_W-1:0] sel;
  } wdog_cfg_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] WR_KEY = 8'h5A,
  parameter logic [KEY_W-1:0] RD_TAG = 8'h69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wipe,
  output wdog_cfg_t        cfg,
  output logic             wr_bad,
  output logic             clr_hit,
  output logic [REG_W-1:0] rd_data
);
  localparam int LOW_W = REG_W - KEY_W;
  localparam logic [LOW_W-1:0] USED_MASK =
    LOW_W'((1 << HOLD_BIT) | (1 << MODE_BIT) | (1 << CLR_BIT) | (((1 << SEL_W) - 1) << SEL_LSB));

  logic             key_ok;
  logic             wr_ok;
  logic [REG_W-1:0] rd_view;
  logic             unused_bits;

  assign key_ok      = (wr_data[REG_W-1 -: KEY_W] == WR_KEY);
  assign wr_ok       = wr_en & key_ok;
  assign wr_bad      = wr_en & ~key_ok;
  assign clr_hit     = wr_ok & wr_data[CLR_BIT];
  assign unused_bits = ^(wr_data[LOW_W-1:0] & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      cfg <= '0;
    end else if (wr_ok) begin
      cfg.hold     <= wr_data[HOLD_BIT];
      cfg.interval <= wr_data[MODE_BIT];
      cfg.sel      <= wr_data[SEL_LSB +: SEL_W];
    end
  end

  always_comb begin
    rd_view                      = '0;
    rd_view[REG_W-1 -: KEY_W]    = RD_TAG;
    rd_view[HOLD_BIT]            = cfg.hold;
    rd_view[MODE_BIT]            = cfg.interval;
    rd_view[SEL_LSB +: SEL_W]    = cfg.sel;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= {RD_TAG, {LOW_W{1'b0}}};
    else     rd_data <= rd_view;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int EXP0  = 15,
  parameter int EXP1  = 13,
  parameter int EXP2  = 9,
  parameter int EXP3  = 6,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam int NSEL = 1 << SEL_W;
  localparam int EXPS [4] = '{EXP0, EXP1, EXP2, EXP3};

  logic [CNT_W-1:0] lim [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim[g] = CNT_W'((64'd1 << EXPS[g]) - 64'd1);
  end

  assign expire = run && (cnt >= lim[sel]);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_event.sv
module wdog_event (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic interval,
  input  logic clr_hit,
  input  logic wr_bad,
  input  logic irq_ack,
  output logic dog_fire,
  output logic int_set,
  output logic rst_req,
  output logic irq
);
  logic live_exp;

  assign live_exp = expire & ~clr_hit;
  assign dog_fire = (live_exp & ~interval) | wr_bad;
  assign int_set  = live_exp & interval & ~wr_bad;

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= dog_fire;
  end

  always_ff @(posedge clk) begin
    if (rst || dog_fire) irq <= 1'b0;
    else if (int_set)    irq <= 1'b1;
    else if (irq_ack)    irq <= 1'b0;
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] WR_KEY = 8'h5A,
  parameter logic [KEY_W-1:0] RD_TAG = 8'h69,
  parameter int EXP0 = 15,
  parameter int EXP1 = 13,
  parameter int EXP2 = 9,
  parameter int EXP3 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             irq_ack_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  localparam int CNT_W = max4(EXP0, EXP1, EXP2, EXP3);

  wdog_cfg_t        cfg;
  logic             wr_bad;
  logic             clr_hit;
  logic             dog_fire;
  logic             int_set;
  logic             expire;
  logic [CNT_W-1:0] cnt_q;

  wdog_cfg_reg #(
    .REG_W(REG_W), .KEY_W(KEY_W), .WR_KEY(WR_KEY), .RD_TAG(RD_TAG)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .wipe(dog_fire), .cfg(cfg), .wr_bad(wr_bad), .clr_hit(clr_hit),
    .rd_data(rd_data_o)
  );

  wdog_count #(
    .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .run(~cfg.hold),
    .restart(clr_hit | wr_bad | expire),
    .sel(cfg.sel), .cnt(cnt_q), .expire(expire)
  );

  wdog_event u_evt (
    .clk(clk), .rst(rst), .expire(expire), .interval(cfg.interval),
    .clr_hit(clr_hit), .wr_bad(wr_bad), .irq_ack(irq_ack_i),
    .dog_fire(dog_fire), .int_set(int_set),
    .rst_req(rst_req_o), .irq(irq_o)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int REG_W = 16,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] WR_KEY = 8'h5A,
  parameter logic [KEY_W-1:0] RD_TAG = 8'h69,
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             rst_req_o,
  input logic             irq_o,
  input logic             hold,
  input logic [CNT_W-1:0] cnt,
  input logic             int_set
);
  logic bad_wr;
  assign bad_wr = wr_en_i && (wr_data_i[REG_W-1 -: KEY_W] != WR_KEY);

  AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> rst_req_o); // R7

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o && !bad_wr) |=> !rst_req_o); // R8

  AST_WIPE_TO_POWERUP: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o && !wr_en_i) |=> (rd_data_o == {RD_TAG, {(REG_W-KEY_W){1'b0}}})); // R8

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_en_i) |=> $stable(cnt)); // R6

  AST_IRQ_NOT_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !rst_req_o); // R9

  AST_ACK_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    int_set |=> irq_o); // R10
endmodule

bind wdog_guard wdog_guard_chk #(
  .REG_W(REG_W), .KEY_W(KEY_W), .WR_KEY(WR_KEY), .RD_TAG(RD_TAG), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .rst_req_o(rst_req_o), .irq_o(irq_o),
  .hold(cfg.hold), .cnt(cnt_q), .int_set(int_set)
);

// File: tb/tb_wdog_guard.sv
module tb_wdog_guard;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        irq_ack_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rst_req_o;
  logic        irq_o;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  logic  irq_prev = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  wdog_guard dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .irq_ack_i(irq_ack_i), .rd_data_o(rd_data_o), .rst_req_o(rst_req_o),
    .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard: item = edge*2 + kind (kind 0 = reset pulse, 1 = interrupt rise)
  task automatic expect_evt(input int edge_no, input int kind, input string tag);
    exp_q.push_back(edge_no * 2 + kind);
    tag_q.push_back(tag);
  endtask

  task automatic sb_event(input int kind);
    int    item;
    int    want;
    string tag;
    item = cyc * 2 + kind;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R2/R9 unexpected event actual=%0d expected=none", item);
    end else begin
      want = exp_q.pop_front();
      tag  = tag_q.pop_front();
      if (want != item) begin
        fails++;
        $display("FAIL %s event actual=%0d expected=%0d", tag, item, want);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      irq_prev <= 1'b0;
    end else begin
      if (rst_req_o) sb_event(0);
      if (irq_o && !irq_prev) sb_event(1);
      irq_prev <= irq_o;
    end
  end

  task automatic wr(input logic [15:0] d, output int edge_no);
    edge_no   = cyc + 1;
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic ack_pulse();
    irq_ack_i = 1'b1;
    @(negedge clk);
    irq_ack_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected<200000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int e, e2, h;
    repeat (3) @(negedge clk);
    chk(rd_data_o == 16'h6900, "R1 read in reset", rd_data_o, 16'h6900);
    chk(!rst_req_o && !irq_o, "R1 outputs in reset", {rst_req_o, irq_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data_o == 16'h6900, "R1 read after reset", rd_data_o, 16'h6900);

    // R2: untouched block fires after 2^15 edges
    expect_evt(32768, 0, "R2 power-up expiry");
    wait_until(32770);

    // R4 / R3: select 11 with clear, read back shows fields, clear reads 0
    wr(16'h5A0B, e);
    expect_evt(e + 64, 0, "R4 select 11");
    @(negedge clk);
    chk(rd_data_o == 16'h6903, "R3 readback clear reads 0", rd_data_o, 16'h6903);
    wait_until(e + 66);

    // R4 select 10, then R8 fields back to reset values after expiry
    wr(16'h5A0A, e);
    expect_evt(e + 512, 0, "R4 select 10");
    wait_until(e + 514);
    chk(rd_data_o == 16'h6900, "R8 fields wiped by expiry", rd_data_o, 16'h6900);

    // R4 select 01
    wr(16'h5A09, e);
    expect_evt(e + 8192, 0, "R4 select 01");
    wait_until(e + 8194);

    // R5: regular servicing keeps it quiet
    wr(16'h5A0B, e);
    for (int i = 0; i < 3; i++) begin
      wait_until(e + 49);
      wr(16'h5A0B, e);
    end
    expect_evt(e + 64, 0, "R5 after servicing");
    wait_until(e + 66);

    // R5: servicing on the expiry edge itself cancels it
    wr(16'h5A0B, e);
    wait_until(e + 63);
    wr(16'h5A0B, e2);
    chk(e2 == e + 64, "R5 collision edge", e2, e + 64);
    expect_evt(e2 + 64, 0, "R5 collision service");
    wait_until(e2 + 66);

    // R6: hold freezes at 30, resume continues from 30
    wr(16'h5A0B, e);
    wait_until(e + 29);
    wr(16'h5A83, h);
    repeat (200) @(negedge clk);
    chk(rd_data_o == 16'h6983, "R6 hold readback", rd_data_o, 16'h6983);
    wr(16'h5A03, h);
    expect_evt(h + 34, 0, "R6 resume from frozen count");
    wait_until(h + 36);

    // R9 / R10: interval mode
    wr(16'h5A1B, e);
    expect_evt(e + 64, 1, "R9 interval first");
    wait_until(e + 70);
    chk(irq_o == 1'b1, "R10 flag held", irq_o, 1);
    ack_pulse();
    chk(irq_o == 1'b0, "R10 ack clears", irq_o, 0);
    expect_evt(e + 128, 1, "R9 interval periodic");
    wait_until(e + 191);
    ack_pulse();
    chk(irq_o == 1'b1, "R10 set wins over ack", irq_o, 1);
    ack_pulse();
    chk(irq_o == 1'b0, "R10 second ack", irq_o, 0);
    wr(16'h5A93, h);
    @(negedge clk);
    chk(rd_data_o == 16'h6993, "R3 interval hold readback", rd_data_o, 16'h6993);

    // R7: wrong key fires at once and restores the reset state
    expect_evt(cyc + 1, 0, "R7 wrong key");
    wr(16'h3303, e);
    @(negedge clk);
    chk(rd_data_o == 16'h6900, "R7 state back to reset", rd_data_o, 16'h6900);
    expect_evt(e + 32768, 0, "R7 fresh power-up count");
    wait_until(e + 32772);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule